// File: doc/BRIEF.md
# Backlight PWM Divider Pair Selector

This block picks the two divider settings a display sink needs to turn a fixed 27 MHz reference into a requested backlight PWM rate. The first setting is an 8-bit prescaler F. The second is a bit-count exponent Pn, so the sink divides the reference by F·2^Pn. A request carries the rate in hertz and the sink's lowest and highest supported exponents.

The block runs a multi-cycle job. An iterative divider forms the target product 27,000,000 / rate. The block then forms a tolerance window around that product and tests whether any exponent in the sink's range could reach it. It then walks the exponents from the highest downward, testing one candidate per clock. A larger exponent is preferred because it leaves more duty-cycle bits and so gives finer brightness steps.

The result is presented together with a one-cycle done strobe and a set of outcome flags. A rate of zero means the sink keeps its own default rate, and the block programs nothing.

Top module: `pwm_div_sel`

## Requirements
- R1: A start with freq_hz_i = 0 produces done_o with skip_o = 1, range_err_o = 0, no_match_o = 0, prescale_o = 0 and exp_o = 0.
- R2: For a nonzero rate, the target product T is the integer quotient floor(27,000,000 / freq_hz_i). The window bounds are lo = floor(3·T/4) and hi = floor(5·T/4), and both bounds are included in the window.
- R3: Only bits [4:0] of pn_min_cap_i and pn_max_cap_i are used. Bits [7:5] have no effect on any result.
- R4: The request is rejected with range_err_o = 1, prescale_o = 0 and exp_o = 0 in any of three cases: min > max; lo < 2^min; or 255·2^max < hi. Here min and max are the masked exponent limits.
- R5: Otherwise the exponents are tried from max down to min inclusive. The first exponent whose product prescale·2^Pn lies in [lo, hi] is returned in exp_o, with its prescaler in prescale_o.
- R6: The prescaler for an exponent p is computed in two steps. For p > 0 it is (T + 2^(p−1)) >> p, and for p = 0 it is T. The value is then clamped to the range 1 to 255.
- R7: If no exponent in the range lands in the window, the block returns the candidate for min and raises no_match_o = 1.
- R8: done_o is high for exactly one cycle per accepted start. busy_o is high from the cycle after a nonzero-rate start until done_o rises, and busy_o is low while done_o is high.
- R9: start_i is ignored while busy_o is high. The result is the one for the request that started the job.
- R10: prescale_o, exp_o and the flags hold their values from done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe; sampled only while idle |
| freq_hz_i | input | 32 | Requested PWM rate in Hz |
| pn_min_cap_i | input | 8 | Sink's lowest exponent; low 5 bits used |
| pn_max_cap_i | input | 8 | Sink's highest exponent; low 5 bits used |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle result strobe |
| skip_o | output | 1 | Zero rate requested; nothing to program |
| range_err_o | output | 1 | No exponent can satisfy the window |
| no_match_o | output | 1 | Search ended without a window hit |
| prescale_o | output | 8 | Selected prescaler F |
| exp_o | output | 5 | Selected exponent Pn |

## Verification
The assertions assume three things. First, the divider is launched only with a nonzero divisor, which holds because a zero rate is handled before the divide. Second, request inputs matter only in the cycle start_i is seen while idle. Third, the exponent limits have already passed the ordering check before the search runs. The stimulus holds start_i for a single cycle at a time, except for a deliberate second pulse sent in the middle of a job. It draws rates that span both sides of 27 MHz, so the zero-product and oversized-product paths are both reached. It fills the unused capability bits with random values so that the masking is exercised.

// File: rtl/pwm_div_pkg.sv
package pwm_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIV    = 2'd1,
    ST_CHECK  = 2'd2,
    ST_SEARCH = 2'd3
  } sel_state_e;
endpackage

// File: rtl/pwm_div_restoring.sv
module pwm_div_restoring #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  q_q, d_q;
  logic [W:0]    r_q, r_sh, r_nx;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q, ge;

  always_comb begin
    r_sh = {r_q[W-1:0], q_q[W-1]};
    ge   = r_sh >= {1'b0, d_q};
    r_nx = ge ? r_sh - {1'b0, d_q} : r_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      d_q    <= '0;
      r_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        q_q   <= dividend_i;
        d_q   <= divisor_i;
        r_q   <= '0;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        q_q   <= {q_q[W-2:0], ge};
        r_q   <= r_nx;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign quot_o = q_q;
  assign done_o = done_q;

  p_rem_below_divisor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (r_q < {1'b0, d_q}));
  p_nonzero_divisor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (divisor_i != '0));
endmodule

// File: rtl/pwm_div_window.sv
module pwm_div_window #(
  parameter int unsigned FW = 32,
  parameter int unsigned EW = 5,
  parameter int unsigned PW = 8,
  localparam int unsigned XW = FW + PW
) (
  input  logic [FW-1:0] prod_i,
  input  logic [EW-1:0] pn_min_i,
  input  logic [EW-1:0] pn_max_i,
  output logic [XW-1:0] lo_o,
  output logic [XW-1:0] hi_o,
  output logic          feasible_o
);
  localparam logic [XW-1:0] PMAX = XW'((1 << PW) - 1);

  logic [XW-1:0] ext, floor_reach, ceil_reach;

  always_comb begin
    ext         = XW'(prod_i);
    lo_o        = (ext * XW'(3)) >> 2;
    hi_o        = (ext * XW'(5)) >> 2;
    floor_reach = XW'(1) << pn_min_i;
    ceil_reach  = PMAX << pn_max_i;
    feasible_o  = (pn_min_i <= pn_max_i) && (lo_o >= floor_reach) && (ceil_reach >= hi_o);
  end
endmodule

// File: rtl/pwm_div_cand.sv
module pwm_div_cand #(
  parameter int unsigned FW = 32,
  parameter int unsigned EW = 5,
  parameter int unsigned PW = 8,
  localparam int unsigned XW = FW + PW
) (
  input  logic [FW-1:0] prod_i,
  input  logic [EW-1:0] pn_i,
  input  logic [XW-1:0] lo_i,
  input  logic [XW-1:0] hi_i,
  output logic [PW-1:0] pre_o,
  output logic          in_win_o
);
  localparam logic [XW-1:0] PMAX = XW'((1 << PW) - 1);

  logic [XW-1:0] half, rounded, clamped, actual;

  always_comb begin
    half    = (pn_i == '0) ? '0 : (XW'(1) << (pn_i - 1'b1));
    rounded = (XW'(prod_i) + half) >> pn_i;
    if (rounded == '0)      clamped = XW'(1);
    else if (rounded > PMAX) clamped = PMAX;
    else                    clamped = rounded;
    pre_o    = clamped[PW-1:0];
    actual   = clamped << pn_i;
    in_win_o = (actual >= lo_i) && (actual <= hi_i);
  end
endmodule

// File: rtl/pwm_div_sel.sv
module pwm_div_sel
  import pwm_div_pkg::*;
#(
  parameter int unsigned BASE_HZ = 27_000_000,
  parameter int unsigned FW      = 32,
  parameter int unsigned EW      = 5,
  parameter int unsigned PW      = 8,
  parameter int unsigned CAPW    = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [FW-1:0]   freq_hz_i,
  input  logic [CAPW-1:0] pn_min_cap_i,
  input  logic [CAPW-1:0] pn_max_cap_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            skip_o,
  output logic            range_err_o,
  output logic            no_match_o,
  output logic [PW-1:0]   prescale_o,
  output logic [EW-1:0]   exp_o
);
  localparam int unsigned XW = FW + PW;

  sel_state_e    st_q;
  logic [FW-1:0] prod_q, quot;
  logic [EW-1:0] pn_min_q, pn_max_q, pn_q;
  logic          div_start, div_done, feasible, in_win;
  logic [XW-1:0] lo, hi;
  logic [PW-1:0] cand_pre;
  logic          done_q, skip_q, rng_q, nm_q;
  logic [PW-1:0] pre_q;
  logic [EW-1:0] exp_q;

  assign div_start = (st_q == ST_IDLE) && start_i && (freq_hz_i != '0);

  pwm_div_restoring #(.W(FW)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (FW'(BASE_HZ)),
    .divisor_i  (freq_hz_i),
    .quot_o     (quot),
    .done_o     (div_done)
  );

  pwm_div_window #(.FW(FW), .EW(EW), .PW(PW)) i_win (
    .prod_i     (prod_q),
    .pn_min_i   (pn_min_q),
    .pn_max_i   (pn_max_q),
    .lo_o       (lo),
    .hi_o       (hi),
    .feasible_o (feasible)
  );

  pwm_div_cand #(.FW(FW), .EW(EW), .PW(PW)) i_cand (
    .prod_i   (prod_q),
    .pn_i     (pn_q),
    .lo_i     (lo),
    .hi_i     (hi),
    .pre_o    (cand_pre),
    .in_win_o (in_win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      prod_q   <= '0;
      pn_min_q <= '0;
      pn_max_q <= '0;
      pn_q     <= '0;
      done_q   <= 1'b0;
      skip_q   <= 1'b0;
      rng_q    <= 1'b0;
      nm_q     <= 1'b0;
      pre_q    <= '0;
      exp_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          pn_min_q <= pn_min_cap_i[EW-1:0];
          pn_max_q <= pn_max_cap_i[EW-1:0];
          if (freq_hz_i == '0) begin
            done_q <= 1'b1;
            skip_q <= 1'b1;
            rng_q  <= 1'b0;
            nm_q   <= 1'b0;
            pre_q  <= '0;
            exp_q  <= '0;
          end else begin
            st_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          prod_q <= quot;
          st_q   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (feasible) begin
            pn_q <= pn_max_q;
            st_q <= ST_SEARCH;
          end else begin
            done_q <= 1'b1;
            skip_q <= 1'b0;
            rng_q  <= 1'b1;
            nm_q   <= 1'b0;
            pre_q  <= '0;
            exp_q  <= '0;
            st_q   <= ST_IDLE;
          end
        end
        ST_SEARCH: begin
          if (in_win || pn_q == pn_min_q) begin
            done_q <= 1'b1;
            skip_q <= 1'b0;
            rng_q  <= 1'b0;
            nm_q   <= !in_win;
            pre_q  <= cand_pre;
            exp_q  <= pn_q;
            st_q   <= ST_IDLE;
          end else begin
            pn_q <= pn_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign skip_o      = skip_q;
  assign range_err_o = rng_q;
  assign no_match_o  = nm_q;
  assign prescale_o  = pre_q;
  assign exp_o       = exp_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_flags_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $onehot0({skip_o, range_err_o, no_match_o}));
  p_search_bounds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SEARCH) |-> (pn_q >= pn_min_q && pn_q <= pn_max_q));
  p_prescale_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !skip_o && !range_err_o) |-> (prescale_o != '0));
  p_hit_in_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !skip_o && !range_err_o && !no_match_o) |->
      ((XW'(prescale_o) << exp_o) >= lo && (XW'(prescale_o) << exp_o) <= hi));
  p_nomatch_at_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && no_match_o) |-> (exp_o == pn_min_q));
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(pn_min_q) && $stable(pn_max_q)));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(prescale_o) && $stable(exp_o) && $stable(range_err_o)));
endmodule

// File: tb/test_pwm_div_sel.sv
module test_pwm_div_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] freq_hz_i = '0;
  logic [7:0]  pn_min_cap_i = '0, pn_max_cap_i = '0;
  logic        busy_o, done_o, skip_o, range_err_o, no_match_o;
  logic [7:0]  prescale_o;
  logic [4:0]  exp_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4ns clk_i = ~clk_i;

  pwm_div_sel i_pwm_div_sel (
    .clk_i, .rst_ni, .start_i, .freq_hz_i, .pn_min_cap_i, .pn_max_cap_i,
    .busy_o, .done_o, .skip_o, .range_err_o, .no_match_o, .prescale_o, .exp_o
  );

  task automatic chk(input string req, input longint act, input longint exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Expected outcome from the requirements: flags {skip,rng,nm}
  task automatic model(input longint fr, input int cmin, input int cmax,
                       output int f, output int pn, output int fl);
    longint t, lo, hi, r, act;
    int mn, mx;
    mn = cmin & 31;
    mx = cmax & 31;
    f = 0; pn = 0;
    if (fr == 0) begin fl = 4; return; end
    t  = 27000000 / fr;
    lo = (t * 3) / 4;
    hi = (t * 5) / 4;
    if (mn > mx || lo < (64'd1 << mn) || (64'd255 << mx) < hi) begin fl = 2; return; end
    for (int p = mx; p >= mn; p--) begin
      r = (p == 0) ? t : ((t + (64'd1 << (p - 1))) >> p);
      if (r < 1) r = 1;
      if (r > 255) r = 255;
      act = r << p;
      f = int'(r); pn = p;
      if (act >= lo && act <= hi) begin fl = 0; return; end
    end
    fl = 1;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (done_o) begin ok = 1; return; end
    end
  endtask

  task automatic run(input longint fr, input int cmin, input int cmax, input bit poke);
    int f, pn, fl;
    bit ok;
    model(fr, cmin, cmax, f, pn, fl);
    @(negedge clk_i);
    freq_hz_i = fr[31:0]; pn_min_cap_i = cmin[7:0]; pn_max_cap_i = cmax[7:0];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (fr != 0) begin
      chk("R8 busy after start", busy_o, 1);
      if (poke) begin // R9: second request mid-job
        @(negedge clk_i);
        freq_hz_i = 32'd7; pn_min_cap_i = 8'd0; pn_max_cap_i = 8'd0;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end
      wait_done(ok);
    end else begin
      ok = done_o;
    end
    chk("R8 done seen", ok, 1);
    chk("R1 skip", skip_o, (fl == 4));
    chk("R4 range_err", range_err_o, (fl == 2));
    chk("R7 no_match", no_match_o, (fl == 1));
    chk(poke ? "R9 prescale" : "R5 R6 prescale", prescale_o, f);
    chk(poke ? "R9 exp" : "R5 exp", exp_o, pn);
    @(negedge clk_i);
    chk("R8 done one cycle", done_o, 0);
    chk("R8 idle after done", busy_o, 0);
    repeat (3) @(negedge clk_i);
    chk("R10 prescale held", prescale_o, f);
    chk("R10 exp held", exp_o, pn);
  endtask

  initial begin
    #(8ns * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    chk("reset done", done_o, 0);
    chk("reset busy", busy_o, 0);
    chk("reset prescale", prescale_o, 0);
    chk("reset exp", exp_o, 0);
    rst_ni = 1'b1;
    run(0, 3, 9, 0);                  // R1
    run(200, 0, 31, 0);               // R5 R6 wide search
    run(27000000, 0, 31, 0);          // R4 low bound below 2^min
    run(1, 0, 0, 0);                  // R4 upper reach too small
    run(1000, 9, 4, 0);               // R4 min above max
    run(270000, 8'hE6, 8'hE6, 0);     // R7 + R3 masked caps
    run(270000, 6, 6, 0);             // R7 same result unmasked
    run(3000, 8'hA0, 8'hEF, 0);       // R3
    run(3000, 0, 15, 0);              // R3 compare
    run(50000000, 0, 31, 0);          // R2 zero product
    run(20000, 2, 12, 1);             // R9
    for (int i = 0; i < 60; i++) begin
      longint fr;
      case ($urandom_range(0, 3))
        0: fr = $urandom_range(50, 2000);
        1: fr = $urandom_range(2000, 200000);
        2: fr = $urandom_range(1, 30000000);
        default: fr = $urandom();
      endcase
      run(fr, int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), (i % 7) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule